// File: doc/BRIEF.md
# Wrapping Counter with Compare-Match Events

This block is a free-running binary up-counter with a bank of compare slots. The counter starts at zero after reset, advances by one on every clock and rolls from all ones back to zero without pausing. The count serves as a timebase. Each compare slot holds a value, and when an enabled slot's value equals the live count, that slot raises a sticky match flag. Any raised flag drives a dedicated compare interrupt.

Software schedules a one-shot event by reading the live count, adding the wanted delay with plain modular addition, writing the sum into a slot and enabling it. Because the counter keeps running and wraps, a target that lies past the roll-over point fires correctly after the wrap. A slot fires at most once per full counter period, and nothing reloads it, so events are one-shot only. Software acknowledges an event by writing a one to the slot's flag bit.

Register map (word addresses on a `ADDR_W`-bit address): 0 reads the live count; 1 holds the slot enable mask (bit k enables slot k, read/write); 2 holds the match flags (bit k belongs to slot k; a read returns the flags; a write clears every flag whose data bit is 1); 8+k holds the compare value of slot k (read/write). Reads are combinational from `rd_addr`. Writes take effect at the rising clock edge where `wr_en` is high.

Top module: `wrap_match_timer`

## Requirements
- R1: While reset is held and right after it, the count, the enable mask, every flag, every compare value and `cmp_irq` read as zero.
- R2: Each clock after reset, the count read at address 0 grows by exactly one.
- R3: From the all-ones value the count goes to zero on the next clock and keeps counting.
- R4: When slot k is enabled and its compare value equals the count at a clock edge, flag bit k reads 1 after that edge.
- R5: A slot whose enable bit is 0 never sets its flag, even when its compare value passes under the count.
- R6: A flag stays set until a write to address 2 with that bit at 1; writing 0 in that bit, or writing 1 in other bits, leaves it set.
- R7: If a match and a clearing write hit the same flag at the same edge, the flag ends up set.
- R8: `cmp_irq` is 1 exactly when at least one flag bit is 1.
- R9: A compare value written as (count + delta) mod 2^COUNT_W fires after delta clocks, also when that sum wraps past zero.
- R10: Enable mask and compare values hold what was last written to them and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | COUNT_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | COUNT_W | Read data for rd_addr |
| cmp_irq | output | 1 | Compare-match interrupt |

## Verification
The case that is hardest to reach from the ports is a match that lies beyond the roll-over: with a full-width counter the wrap takes billions of clocks. The bench narrows the counter to eight bits through its width parameter, so the wrap comes every 256 clocks, and then writes a target of count plus a delta that crosses zero. A clear that lands on the same edge as a match is reached by lining up the clearing write with the count read back from the bench's own model.

// File: rtl/wmt_pkg.sv
package wmt_pkg;
  // word addresses inside the block
  localparam int unsigned WMT_A_COUNT = 0;
  localparam int unsigned WMT_A_ENABLE = 1;
  localparam int unsigned WMT_A_FLAGS = 2;
  localparam int unsigned WMT_A_SLOT0 = 8;
endpackage

// File: rtl/wmt_counter.sv
module wmt_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&count_q) |=> (count_q == '0));

  p_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_q != $past(count_q)));
endmodule

// File: rtl/wmt_slot.sv
module wmt_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         arm,
  input  logic         clr,
  output logic [W-1:0] value,
  output logic         flag,
  output logic         hit
);
  logic [W-1:0] value_q, value_d;
  logic         flag_q, flag_d;

  always_comb begin
    hit     = arm && (count == value_q);
    value_d = load ? load_val : value_q;
    flag_d  = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (load) value_q <= value_d;
      flag_q <= flag_d;
    end
  end

  assign value = value_q;
  assign flag  = flag_q;

  p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && (count == value_q)) |=> flag_q);

  p_quiet_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !arm) |=> !flag_q);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  p_value_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(value_q));
endmodule

// File: rtl/wrap_match_timer.sv
module wrap_match_timer
  import wmt_pkg::*;
#(
  parameter int unsigned COUNT_W = 32,
  parameter int unsigned NUM_CMP = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [COUNT_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [COUNT_W-1:0] rd_data,
  output logic               cmp_irq
);
  localparam int unsigned SLOT_END = WMT_A_SLOT0 + NUM_CMP;

  initial begin
    if (COUNT_W < NUM_CMP) $error("COUNT_W must cover one bit per slot");
    if (SLOT_END > (1 << ADDR_W)) $error("address space too small for slots");
  end

  logic [COUNT_W-1:0] count;
  logic [NUM_CMP-1:0] en_q, en_d;
  logic [NUM_CMP-1:0] flag_vec, hit_vec, clr_vec, load_vec;
  logic [COUNT_W-1:0] cmp_vals [NUM_CMP];
  logic               sel_en, sel_flag;

  wmt_counter #(.W(COUNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .count (count)
  );

  always_comb begin
    sel_en   = wr_en && (wr_addr == ADDR_W'(WMT_A_ENABLE));
    sel_flag = wr_en && (wr_addr == ADDR_W'(WMT_A_FLAGS));
    en_d     = sel_en ? wr_data[NUM_CMP-1:0] : en_q;
    clr_vec  = sel_flag ? wr_data[NUM_CMP-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (sel_en) en_q <= en_d;
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_slot
    assign load_vec[k] = wr_en && (wr_addr == ADDR_W'(WMT_A_SLOT0 + k));

    wmt_slot #(.W(COUNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (count),
      .load     (load_vec[k]),
      .load_val (wr_data),
      .arm      (en_q[k]),
      .clr      (clr_vec[k]),
      .value    (cmp_vals[k]),
      .flag     (flag_vec[k]),
      .hit      (hit_vec[k])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(WMT_A_COUNT))  rd_data = count;
    if (rd_addr == ADDR_W'(WMT_A_ENABLE)) rd_data = COUNT_W'(en_q);
    if (rd_addr == ADDR_W'(WMT_A_FLAGS))  rd_data = COUNT_W'(flag_vec);
    for (int k = 0; k < NUM_CMP; k++) begin
      if (rd_addr == ADDR_W'(WMT_A_SLOT0 + k)) rd_data = cmp_vals[k];
    end
  end

  assign cmp_irq = |flag_vec;

  p_irq_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_irq) |-> $past(|hit_vec));

  p_irq_drops_on_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_irq) |-> $past(sel_flag));

  p_hit_onehot_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((flag_vec & $past(hit_vec)) == $past(hit_vec)));

  p_enable_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en |=> $stable(en_q));
endmodule

// File: tb/wrap_match_timer_bench.sv
`timescale 1ns/1ps
module wrap_match_timer_bench;
  localparam int CW = 8;
  localparam int NS = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          cmp_irq;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  wrap_match_timer #(.COUNT_W(CW), .NUM_CMP(NS), .ADDR_W(AW)) u_wrap_match_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cmp_irq(cmp_irq)
  );

  // behavioural model
  int m_cnt;
  int m_en;
  int m_flags;
  int m_cmp [NS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_flags = 0;
      for (int k = 0; k < NS; k++) m_cmp[k] = 0;
    end else begin
      int hits, clr;
      hits = 0;
      clr = 0;
      for (int k = 0; k < NS; k++)
        if (((m_en >> k) & 1) == 1 && m_cmp[k] == m_cnt) hits = hits | (1 << k);
      if (wr_en && wr_addr == 2) clr = int'(wr_data);
      if (wr_en && wr_addr == 1) m_en = int'(wr_data);
      for (int k = 0; k < NS; k++)
        if (wr_en && int'(wr_addr) == 8 + k) m_cmp[k] = int'(wr_data);
      m_flags = (m_flags & ~clr) | hits;
      m_cnt = (m_cnt + 1) % (1 << CW);
    end
  end

  function automatic int model_read(int a);
    if (a == 0) return m_cnt;
    if (a == 1) return m_en;
    if (a == 2) return m_flags;
    if (a >= 8 && a < 8 + NS) return m_cmp[a - 8];
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    check(cur_req, int'(rd_data), model_read(int'(rd_addr)));
    check("R8", int'(cmp_irq), (m_flags != 0) ? 1 : 0);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    step();
    wr_en = 1'b0;
  endtask

  // run until model count equals v (as seen just after a negedge)
  task automatic wait_count(int v);
    while (m_cnt != v) step();
  endtask

  initial begin
    int start;
    // R1: reset state
    step(3);
    for (int a = 0; a < 11; a++) begin
      rd_addr = AW'(a); #1;
      check("R1", int'(rd_data), 0);
    end
    check("R1", int'(cmp_irq), 0);
    rst_n = 1'b1;
    rd_addr = 0;

    // R2: counting
    cur_req = "R2";
    step(20);

    // R3: wrap
    cur_req = "R3";
    wait_count(255);
    check("R3", int'(rd_data), 255);
    step();
    check("R3", int'(rd_data), 0);
    step(5);

    // R10: write and read back enables and compares
    cur_req = "R10";
    wr(8 + 6, 8'hA5);
    wr(8 + 7, 8'h3C);
    rd_addr = 8 + 6; step();
    check("R10", int'(rd_data), 8'hA5);
    rd_addr = 8 + 7; step();
    check("R10", int'(rd_data), 8'h3C);

    // R9 / R4: delta crossing the wrap on slot 3
    cur_req = "R9";
    rd_addr = 0;
    wait_count(240);
    start = m_cnt;
    wr(8 + 3, (start + 1 + 30) % 256);  // count is start+1 when the write lands
    wr(1, 8'b0000_1000);
    rd_addr = 2;
    wait_count((start + 1 + 30) % 256);
    check("R9", int'(rd_data) & 8, 0);   // target not yet reached
    step();
    check("R4", int'(rd_data) & 8, 8);
    check("R8", int'(cmp_irq), 1);

    // R5: slot 5 has a compare value but stays disabled for a full period
    cur_req = "R5";
    wr(8 + 5, 77);
    step(260);
    check("R5", int'(rd_data) & 32, 0);

    // R6: writes of 0 or other bits keep flag 3; a 1 clears it
    cur_req = "R6";
    wr(2, 8'b1111_0111);
    check("R6", int'(rd_data) & 8, 8);
    wr(2, 0);
    check("R6", int'(rd_data) & 8, 8);
    wr(2, 8'b0000_1000);
    check("R6", int'(rd_data) & 8, 0);
    check("R8", int'(cmp_irq), 0);

    // R7: clear on the same edge as a new match on slot 3
    cur_req = "R7";
    wr(8 + 3, 100);
    wait_count(101);
    check("R7", int'(rd_data) & 8, 8);
    wait_count(100);
    wr_en = 1'b1; wr_addr = 2; wr_data = 8'b0000_1000;
    step();
    wr_en = 1'b0;
    check("R7", int'(rd_data) & 8, 8);
    wr(2, 8'hFF);
    wr(1, 0);
    step(20);
    check("R8", int'(cmp_irq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule